// File: doc/BRIEF.md
# Write-Only Serial Register Port

This block is a serial slave that takes 16-bit write commands on an active-low select line, a serial clock and a serial data line, and keeps the settings of a small register file. All three serial lines are brought into the system clock domain through two-flop synchronizers. The block samples the data line on each rising serial-clock edge that it detects in that domain. A command is a register address followed by a data byte, and both are sent most significant bit first. The port has no read path.

A command is committed only when the select line returns high after exactly sixteen clock edges. One address does not store anything. A write to it only raises a single-cycle commit pulse, which the rest of the system uses to load new timing settings. The whole register file is driven out as one flat bus. The block also derives two sideband outputs from it: a ten-bit output-enable vector that is packed across two registers, and the software shutdown bit of the configuration register.

Top module: `wrtonly_spi_port`

## Requirements
- R1: After reset, register 0x00 holds 0x01, register 0x1D holds 0xFF, register 0x1E holds 0xC0, and every other register holds 0x00. Register n sits in bits [8n+7:8n] of `reg_file_o`.
- R2: A frame is sixteen data-line samples, each taken on a rising `spi_sclk` edge while `spi_cs_n` is low. Bits 15..8 are the address and bits 7..0 are the data, both sent MSB first. A valid frame is stored when `spi_cs_n` rises.
- R3: A valid frame addressed to 0x1C stores nothing and raises `commit_o` for exactly one clock. Byte 0x1C of `reg_file_o` always reads 0x00.
- R4: A frame that ends after any number of edges other than sixteen, whether fewer or more, changes no register and raises no commit pulse.
- R5: A valid frame addressed above 0x20 changes no register and raises no commit pulse.
- R6: `out_en_o[7:0]` equals register 0x1D, bit for bit. `out_en_o[9]` equals bit 7 of register 0x1E, and `out_en_o[8]` equals bit 6 of register 0x1E.
- R7: `shutdown_o` equals bit 0 of register 0x00. While it is set, the other registers keep their contents.
- R8: Serial clock edges that occur while `spi_cs_n` is high are ignored. They change no register, and the next frame is still counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock, sampled on its rising edge |
| spi_sdi | input | 1 | Serial data |
| reg_file_o | output | NUM_REGS*8 | Flat image of all registers, register n at bits [8n+7:8n] |
| commit_o | output | 1 | One-cycle pulse on a write to address 0x1C |
| out_en_o | output | 10 | Per-output enable bits |
| shutdown_o | output | 1 | Software shutdown bit |

## Verification
The bench builds the block with its default parameters. These give thirty-three registers ending at address 0x20 and a bit counter that saturates well above sixteen. With these settings, random addresses up to 0x28 reach both the decoded range and the ignored addresses beyond it. Frames of fifteen, seventeen and twenty bits test the saturating counter against the exact-sixteen rule. The serial clock runs twelve system clocks per bit, which leaves margin for the synchronizer latency.

// File: rtl/spi_regfile_pkg.sv
package spi_regfile_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 8;
    localparam int FRAME_BITS  = ADDR_W + DATA_W;
    localparam int CFG_ADDR    = 'h00;
    localparam int COMMIT_ADDR = 'h1C;
    localparam int EN_LO_ADDR  = 'h1D;
    localparam int EN_HI_ADDR  = 'h1E;
    localparam int LAST_ADDR   = 'h20;

    // reset value of register idx
    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            CFG_ADDR:   reset_value = 8'h01;
            EN_LO_ADDR: reset_value = 8'hFF;
            EN_HI_ADDR: reset_value = 8'hC0;
            default:    reset_value = '0;
        endcase
    endfunction
endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic cs_n_s,
    output logic sdi_s,
    output logic sclk_rise,
    output logic cs_rise
);
    typedef struct packed {
        logic [1:0] cs;
        logic [1:0] ck;
        logic [1:0] dt;
        logic       ck_prev;
        logic       cs_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.cs      = {s_q.cs[0], cs_n_i};
        s_d.ck      = {s_q.ck[0], sclk_i};
        s_d.dt      = {s_q.dt[0], sdi_i};
        s_d.ck_prev = s_q.ck[1];
        s_d.cs_prev = s_q.cs[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cs: 2'b11, ck: 2'b00, dt: 2'b00, ck_prev: 1'b0, cs_prev: 1'b1};
        else        s_q <= s_d;
    end

    assign cs_n_s    = s_q.cs[1];
    assign sdi_s     = s_q.dt[1];
    assign sclk_rise = s_q.ck[1] & ~s_q.ck_prev;
    assign cs_rise   = s_q.cs[1] & ~s_q.cs_prev;

    // R2
    sclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_regfile_pkg::*;
#(
    parameter int CNT_W = $clog2(FRAME_BITS) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sdi_s,
    input  logic              sclk_rise,
    input  logic              cs_rise,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
    } shf_t;

    shf_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (cs_n_s) begin
            f_d.cnt = '0;
        end else if (sclk_rise) begin
            f_d.shreg = {f_q.shreg[FRAME_BITS-2:0], sdi_s};
            if (f_q.cnt != CNT_MAX) f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign wr_valid = cs_rise && (f_q.cnt == CNT_FULL);
    assign wr_addr  = f_q.shreg[FRAME_BITS-1:DATA_W];
    assign wr_data  = f_q.shreg[DATA_W-1:0];

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    // R8
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && sclk_rise) |=> (f_q.cnt == '0));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regfile_pkg::*;
#(
    parameter int NUM_REGS = LAST_ADDR + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic                       commit_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            upd;
    } bank_t;

    bank_t b_d, b_q;
    bank_t b_rst;

    always_comb begin
        b_rst.upd = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) b_rst.regs[i] = reset_value(i);
    end

    always_comb begin
        b_d     = b_q;
        b_d.upd = 1'b0;
        if (wr_valid) begin
            if (int'(wr_addr) == COMMIT_ADDR) b_d.upd = 1'b1;
            for (int i = 0; i < NUM_REGS; i++) begin
                if (int'(wr_addr) == i && i != COMMIT_ADDR) b_d.regs[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= b_rst;
        else        b_q <= b_d;
    end

    assign regs_o   = b_q.regs;
    assign commit_o = b_q.upd;

    // R3
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    // R3
    commit_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && int'(wr_addr) == COMMIT_ADDR) |=> $stable(b_q.regs));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(b_q.regs));
    // R5
    far_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && int'(wr_addr) >= NUM_REGS) |=> ($stable(b_q.regs) && !commit_o));
endmodule

// File: rtl/wrtonly_spi_port.sv
module wrtonly_spi_port
    import spi_regfile_pkg::*;
#(
    parameter int NUM_REGS = LAST_ADDR + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_cs_n,
    input  logic                       spi_sclk,
    input  logic                       spi_sdi,
    output logic [NUM_REGS*DATA_W-1:0] reg_file_o,
    output logic                       commit_o,
    output logic [9:0]                 out_en_o,
    output logic                       shutdown_o
);
    logic              cs_n_s, sdi_s, sclk_rise, cs_rise;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    spi_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (spi_cs_n),
        .sclk_i    (spi_sclk),
        .sdi_i     (spi_sdi),
        .cs_n_s    (cs_n_s),
        .sdi_s     (sdi_s),
        .sclk_rise (sclk_rise),
        .cs_rise   (cs_rise)
    );

    spi_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sdi_s     (sdi_s),
        .sclk_rise (sclk_rise),
        .cs_rise   (cs_rise),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .regs_o   (reg_file_o),
        .commit_o (commit_o)
    );

    assign out_en_o   = {reg_file_o[EN_HI_ADDR*DATA_W+7 -: 2],
                         reg_file_o[EN_LO_ADDR*DATA_W+7 -: 8]};
    assign shutdown_o = reg_file_o[CFG_ADDR*DATA_W];

    // R6
    en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || $stable(reg_file_o)) |-> $stable(out_en_o));
endmodule

// File: tb/sim_wrtonly_spi_port.sv
module sim_wrtonly_spi_port;
    localparam int NREG = 33;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [NREG*8-1:0] reg_file;
    logic commit;
    logic [9:0] out_en;
    logic shutdown;

    int errors = 0, checks = 0;
    int upd_seen = 0, upd_exp = 0;
    bit done = 0;
    logic [7:0] exp_r [NREG];

    always #2.5 clk = ~clk;

    wrtonly_spi_port u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
        .reg_file_o(reg_file), .commit_o(commit), .out_en_o(out_en), .shutdown_o(shutdown)
    );

    always @(posedge clk) if (commit) upd_seen++;

    function automatic logic [NREG*8-1:0] exp_vec();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_r[i];
        return v;
    endfunction

    function automatic void model_write(input int nbits, input logic [7:0] a, input logic [7:0] d);
        if (nbits != 16) return;
        if (a == 8'h1C) upd_exp++;
        else if (int'(a) < NREG) exp_r[a] = d;
    endfunction

    task automatic check(input string tag, input logic [NREG*8-1:0] act, input logic [NREG*8-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " regs"}, reg_file, exp_vec());
        check({tag, " commit count R3"}, (NREG*8)'(upd_seen), (NREG*8)'(upd_exp));
        check("R6 out_en", (NREG*8)'(out_en), (NREG*8)'({exp_r[8'h1E][7:6], exp_r[8'h1D]}));
        check("R7 shutdown", (NREG*8)'(shutdown), (NREG*8)'(exp_r[0][0]));
    endtask

    task automatic send(input int nbits, input logic [31:0] word);
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = word[i]; sclk = 1'b0;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        model_write(nbits, word[15:8], word[7:0]);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        send(16, {16'h0, a, d});
    endtask

    initial begin
        void'($urandom(32'd5151));
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
        exp_r[8'h00] = 8'h01; exp_r[8'h1D] = 8'hFF; exp_r[8'h1E] = 8'hC0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R1 reset");

        wr(8'h04, 8'hA5);            check_all("R2 basic write");
        wr(8'h1D, 8'h7F);            check_all("R6 out7 off");
        wr(8'h1E, 8'h40);            check_all("R6 out9 off out8 on");
        wr(8'h1C, 8'h3C);            check_all("R3 commit write");
        send(15, 32'h0000_0B5A);     check_all("R4 short frame");
        send(17, 32'h0001_0B5A);     check_all("R4 17-bit frame");
        send(20, 32'h000F_0C77);     check_all("R4 20-bit frame");
        wr(8'h25, 8'h99);            check_all("R5 far address");
        wr(8'hFF, 8'h11);            check_all("R5 top address");
        wr(8'h20, 8'h6E);            check_all("R2 last address");
        // R8: clock toggles with select high
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); sdi = 1'b1; sclk = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        check_all("R8 idle clocks");
        wr(8'h05, 8'h3D);            check_all("R8 frame after idle clocks");
        wr(8'h00, 8'h01);            check_all("R7 shutdown set keeps regs");
        wr(8'h00, 8'h00);            check_all("R7 shutdown clear");

        for (int n = 0; n < 80; n++) begin
            int sel = $urandom_range(0, 9);
            logic [7:0] a = 8'($urandom_range(0, 40));
            logic [7:0] d = 8'($urandom);
            if (sel == 0)      send(14 + 2 * $urandom_range(0, 2) + 1, {16'h0, a, d});
            else if (sel == 1) wr(8'h1C, d);
            else               wr(a, d);
            check_all("R2 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule